// File: doc/BRIEF.md
# Zero-Bus-Turnaround SRAM Controller

This block sits between a user request port and a zero-bus-turnaround synchronous SRAM of 64K words by 36 bits. A request is a single cycle: a valid flag, a write flag, a 16-bit word address and, for writes, 36 bits of write data, all presented together. The controller registers the address and one read/write control and sends them to the memory. No other control pin is used. Write data goes through its own register stages, so it reaches the memory bus in the data phase that the device expects.

Internal copies of each request's operation travel through a pipeline of matching length. They decide when the 36 output enables turn on. They also decide when returning read data is captured and handed back to the user with a valid strobe. Because nothing waits on the bus direction, reads and writes can be issued in any mix, one per clock, with no idle cycles between them. A parameter selects between pipelined device timing (data two cycles after the address) and flow-through timing (data one cycle after the address).

Top module: `zbt_sram_ctrl`

## Requirements
- R1: A request with `req_valid`=1 presented in cycle U appears on `mem_addr` in cycle U+1, with `mem_wr`=1 for a write (`req_write`=1) and `mem_wr`=0 for a read (`req_write`=0).
- R2: A cycle with `req_valid`=0 is sent to the memory as a read (`mem_wr`=0) whatever `req_write` holds. It writes nothing, it never drives the bus, and it never produces a `rsp_valid` pulse.
- R3: In pipelined mode (`FLOW_THRU`=0), the write data of a write presented in cycle U is on `mem_dq_out` with the output enables high in cycle U+3, two cycles after its address phase.
- R4: All `DATA_W` bits of `mem_dq_oe` always carry the same value. They are high only in the data phase of a write and low in every other cycle.
- R5: In pipelined mode, the data the memory drives in cycle U+3 for a read presented in cycle U is returned on `rsp_rdata` with `rsp_valid`=1 in cycle U+4. Responses come back in the order the reads were issued.
- R6: Any sequence of one request per clock, including a write followed at once by a read and a read followed at once by a write, completes with correct data. No cycle is inserted, and there is never a cycle in which both the controller and the memory drive the bus.
- R7: With `FLOW_THRU`=1, write data of a request in cycle U is driven in cycle U+2, and read data is captured in cycle U+2 and returned in cycle U+3.
- R8: While `rst` is high, and in the cycle after it is first sampled high, `mem_dq_oe` is all zero, `rsp_valid` is 0 and `mem_wr` is 0. Requests in flight when reset is asserted produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the controller and memory |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Write data, same cycle as the address |
| rsp_valid | output | 1 | Read data is valid this cycle |
| rsp_rdata | output | DATA_W | Returned read data |
| mem_addr | output | ADDR_W | Address to the SRAM |
| mem_wr | output | 1 | Read/write control to the SRAM, 1 = write |
| mem_dq_out | output | DATA_W | Data driven toward the SRAM |
| mem_dq_in | input | DATA_W | Data received from the SRAM |
| mem_dq_oe | output | DATA_W | Per-bit output enable of the data bus |

## Verification
The bench runs a pipelined instance and a flow-through instance side by side. Each is attached to a memory model that drives read data in its data phase and flags any cycle where the enables disagree with that phase. The bench aims at back-to-back write-then-read and read-then-write on the same address. An enable that lingers or arrives a cycle early shows up there as a two-driver cycle or as stale read data. It issues idle cycles with the write flag held high, where a design that ignores the valid flag would corrupt memory or emit a spurious response. It also asserts reset with a read in flight, where a pipeline without cleared valid bits would still return data.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  // Operation tag carried alongside the data pipeline
  typedef struct packed {
    logic valid;
    logic write;
  } zbt_op_t;

  localparam int OP_W = $bits(zbt_op_t);
endpackage

// File: rtl/zbt_issue.sv
// Address and read/write control register toward the SRAM.
module zbt_issue #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      mem_wr   <= 1'b0;
    end else begin
      // idle cycles keep the last address and are issued as reads
      if (req_valid) mem_addr <= req_addr;
      mem_wr <= req_valid & req_write;
    end
  end
endmodule

// File: rtl/zbt_delay_line.sv
// Fixed-length register chain; optional reset for control bits.
module zbt_delay_line #(
  parameter int W        = 8,
  parameter int DEPTH    = 2,
  parameter bit RESET_EN = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    logic [W-1:0] nxt;
    if (k == 0) begin : g_head
      assign nxt = din;
    end else begin : g_body
      assign nxt = stg[k-1];
    end

    if (RESET_EN) begin : g_rst
      always_ff @(posedge clk) begin
        if (rst) stg[k] <= '0;
        else     stg[k] <= nxt;
      end
    end else begin : g_norst
      always_ff @(posedge clk) begin
        stg[k] <= nxt;
      end
    end
  end

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/zbt_oe_tree.sv
// Replicated enable registers so no single flop fans out to every pad.
module zbt_oe_tree #(
  parameter int DATA_W = 36,
  parameter int GROUP  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drive_next,
  output logic [DATA_W-1:0] oe
);
  localparam int NGRP = (DATA_W + GROUP - 1) / GROUP;

  logic [NGRP-1:0] en_q;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst) en_q[g] <= 1'b0;
      else     en_q[g] <= drive_next;
    end
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign oe[b] = en_q[b / GROUP];
  end
endmodule

// File: rtl/zbt_rd_return.sv
// Marks the read data phase, captures the bus and returns it.
module zbt_rd_return #(
  parameter int DATA_W = 36
) (
  input  logic               clk,
  input  logic               rst,
  input  zbt_pkg::zbt_op_t   op_late,
  input  logic [DATA_W-1:0]  mem_dq_in,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata
);
  logic rd_phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_phase  <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      rd_phase  <= op_late.valid & ~op_late.write;
      rsp_valid <= rd_phase;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_phase) rsp_rdata <= mem_dq_in;
  end
endmodule

// File: rtl/zbt_sram_ctrl.sv
module zbt_sram_ctrl #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 36,
  parameter bit FLOW_THRU = 1'b0,
  parameter int OE_GROUP  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [DATA_W-1:0] mem_dq_oe
);
  import zbt_pkg::*;

  // cycles from address phase to data phase
  localparam int LAT = FLOW_THRU ? 1 : 2;

  zbt_op_t op_in;
  zbt_op_t op_late;
  logic [OP_W-1:0] op_late_bits;

  assign op_in.valid = req_valid;
  assign op_in.write = req_write;

  zbt_issue #(.ADDR_W(ADDR_W)) u_issue (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .mem_addr  (mem_addr),
    .mem_wr    (mem_wr)
  );

  // operation copy: leaves the chain one cycle before the data phase
  zbt_delay_line #(.W(OP_W), .DEPTH(LAT), .RESET_EN(1'b1)) u_op_line (
    .clk  (clk),
    .rst  (rst),
    .din  (op_in),
    .dout (op_late_bits)
  );
  assign op_late = op_late_bits;

  // write data: last stage is the output register toward the pads
  zbt_delay_line #(.W(DATA_W), .DEPTH(LAT + 1), .RESET_EN(1'b0)) u_data_line (
    .clk  (clk),
    .rst  (rst),
    .din  (req_wdata),
    .dout (mem_dq_out)
  );

  zbt_oe_tree #(.DATA_W(DATA_W), .GROUP(OE_GROUP)) u_oe (
    .clk        (clk),
    .rst        (rst),
    .drive_next (op_late.valid & op_late.write),
    .oe         (mem_dq_oe)
  );

  zbt_rd_return #(.DATA_W(DATA_W)) u_ret (
    .clk       (clk),
    .rst       (rst),
    .op_late   (op_late),
    .mem_dq_in (mem_dq_in),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/zbt_sram_ctrl_chk.sv
module zbt_sram_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 36,
  parameter int LAT    = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_wr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic [DATA_W-1:0] mem_dq_in,
  input logic [DATA_W-1:0] mem_dq_oe
);
  // R8
  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> (mem_dq_oe == '0 && !rsp_valid && !mem_wr));

  // R1
  a_r1_addr_follow: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> mem_addr == $past(req_addr));

  a_r1_write_flag: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> mem_wr);

  // R2
  a_r2_idle_reads: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> !mem_wr);

  // R4
  a_r4_oe_uniform: assert property (@(posedge clk) disable iff (rst)
    (mem_dq_oe == '0) || (mem_dq_oe == '1));

  // R3 / R7: enable exactly LAT cycles after a write address phase
  a_r3_oe_phase: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe[0] == $past(mem_wr, LAT));

  a_r3_wdata_align: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe[0] |-> mem_dq_out == $past(req_wdata, LAT + 1));

  // R5 / R7
  a_r5_rsp_timing: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == $past(req_valid && !req_write, LAT + 2));

  a_r5_rsp_data: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_rdata == $past(mem_dq_in));
endmodule

bind zbt_sram_ctrl zbt_sram_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .LAT    (LAT)
) u_chk (.*);

// File: tb/zbt_sram_ctrl_bench.sv
// Behavioural SRAM: address phase, then data phase LAT cycles later.
module zbt_mem_model #(
  parameter int LAT = 2,
  parameter int AW  = 16,
  parameter int DW  = 36
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [DW-1:0] dq_out,
  input  logic [DW-1:0] oe,
  output logic [DW-1:0] dq_in,
  output logic          bad_oe,
  output logic          clash
);
  logic [7:0]    a_q [LAT];
  logic          w_q [LAT];
  logic [DW-1:0] mem [256];
  logic          drive;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LAT; k++) w_q[k] <= 1'b0;
    end else begin
      a_q[0] <= addr[7:0];
      w_q[0] <= wr;
      for (int k = LAT - 1; k > 0; k--) begin
        a_q[k] <= a_q[k-1];
        w_q[k] <= w_q[k-1];
      end
      if (w_q[LAT-1]) mem[a_q[LAT-1]] <= dq_out;
    end
  end

  assign drive  = !w_q[LAT-1];
  assign dq_in  = drive ? mem[a_q[LAT-1]] : '0;
  assign bad_oe = w_q[LAT-1] ? (oe != '1) : (oe != '0);
  assign clash  = drive && (oe != '0);
endmodule

module zbt_sram_ctrl_bench;
  localparam int AW = 16;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [DW-1:0] req_wdata = '0;

  logic          rsp_valid_p, rsp_valid_f;
  logic [DW-1:0] rsp_rdata_p, rsp_rdata_f;
  logic [AW-1:0] mem_addr_p, mem_addr_f;
  logic          mem_wr_p, mem_wr_f;
  logic [DW-1:0] dq_out_p, dq_out_f, dq_in_p, dq_in_f, oe_p, oe_f;
  logic          bad_p, bad_f, clash_p, clash_f;

  zbt_sram_ctrl #(.FLOW_THRU(1'b0)) u_zbt_sram_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid_p),
    .rsp_rdata(rsp_rdata_p), .mem_addr(mem_addr_p), .mem_wr(mem_wr_p),
    .mem_dq_out(dq_out_p), .mem_dq_in(dq_in_p), .mem_dq_oe(oe_p));

  zbt_sram_ctrl #(.FLOW_THRU(1'b1)) u_zbt_sram_ctrl_ft (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid_f),
    .rsp_rdata(rsp_rdata_f), .mem_addr(mem_addr_f), .mem_wr(mem_wr_f),
    .mem_dq_out(dq_out_f), .mem_dq_in(dq_in_f), .mem_dq_oe(oe_f));

  zbt_mem_model #(.LAT(2)) u_mem_p (
    .clk(clk), .rst(rst), .addr(mem_addr_p), .wr(mem_wr_p), .dq_out(dq_out_p),
    .oe(oe_p), .dq_in(dq_in_p), .bad_oe(bad_p), .clash(clash_p));

  zbt_mem_model #(.LAT(1)) u_mem_f (
    .clk(clk), .rst(rst), .addr(mem_addr_f), .wr(mem_wr_f), .dq_out(dq_out_f),
    .oe(oe_f), .dq_in(dq_in_f), .bad_oe(bad_f), .clash(clash_f));

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  logic [DW-1:0] shadow [256];
  logic [DW-1:0] q_dp [$];
  logic [DW-1:0] q_df [$];
  int            q_cp [$];
  int            q_cf [$];

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one request per call, driven mid-cycle
  task automatic send(input bit v, input bit w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = v;
    req_write = w;
    req_addr  = a;
    req_wdata = d;
    if (v && w) shadow[a[7:0]] = d;
    if (v && !w) begin
      q_dp.push_back(shadow[a[7:0]]);
      q_df.push_back(shadow[a[7:0]]);
      q_cp.push_back(cyc);
      q_cf.push_back(cyc);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain(input int n);
    repeat (n) idle();
  endtask

  // response monitor and bus-phase monitor
  always @(negedge clk) begin
    if (!rst) begin
      chk(!bad_p, "R4 pipelined enable outside write data phase", oe_p, 0);
      chk(!bad_f, "R4 flow-through enable outside write data phase", oe_f, 0);
      chk(!clash_p && !clash_f, "R6 two drivers on bus",
          {clash_p, clash_f}, 0);
    end
    if (rsp_valid_p) begin
      if (q_dp.size() == 0) chk(1'b0, "R2 unexpected pipelined response", 1, 0);
      else begin
        logic [DW-1:0] d;
        int c;
        d = q_dp.pop_front();
        c = q_cp.pop_front();
        chk(rsp_rdata_p == d, "R5 pipelined read data", rsp_rdata_p, d);
        chk(cyc == c + 4, "R5 pipelined response cycle", cyc - c, 4);
      end
    end
    if (rsp_valid_f) begin
      if (q_df.size() == 0) chk(1'b0, "R2 unexpected flow-through response", 1, 0);
      else begin
        logic [DW-1:0] d;
        int c;
        d = q_df.pop_front();
        c = q_cf.pop_front();
        chk(rsp_rdata_f == d, "R7 flow-through read data", rsp_rdata_f, d);
        chk(cyc == c + 3, "R7 flow-through response cycle", cyc - c, 3);
      end
    end
  end

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    chk(oe_p == '0 && oe_f == '0, "R8 enables in reset", {oe_p[0], oe_f[0]}, 0);
    chk(!rsp_valid_p && !rsp_valid_f, "R8 response in reset",
        {rsp_valid_p, rsp_valid_f}, 0);
    chk(!mem_wr_p && !mem_wr_f, "R8 control in reset", {mem_wr_p, mem_wr_f}, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_issue_fields();
    send(1, 1, 16'h0012, 36'h1_2345_6789);
    idle();
    chk(mem_addr_p == 16'h0012, "R1 write address", mem_addr_p, 16'h0012);
    chk(mem_wr_p && mem_wr_f, "R1 write control", {mem_wr_p, mem_wr_f}, 2'b11);
    send(1, 0, 16'h0012, '0);
    idle();
    chk(mem_addr_f == 16'h0012, "R1 read address", mem_addr_f, 16'h0012);
    chk(!mem_wr_p && !mem_wr_f, "R1 read control", {mem_wr_p, mem_wr_f}, 0);
    drain(6);
  endtask

  task automatic t_write_timing();
    send(1, 1, 16'h0021, 36'hA_BCDE_F012);
    idle(); // address phase
    idle(); // flow-through data phase
    chk(oe_f == '1 && dq_out_f == 36'hA_BCDE_F012, "R7 flow-through write data",
        dq_out_f, 36'hA_BCDE_F012);
    chk(oe_p == '0, "R4 pipelined enable early", oe_p, 0);
    idle(); // pipelined data phase
    chk(oe_p == '1, "R3 pipelined enable", oe_p, {DW{1'b1}});
    chk(dq_out_p == 36'hA_BCDE_F012, "R3 pipelined write data",
        dq_out_p, 36'hA_BCDE_F012);
    chk(oe_f == '0, "R7 flow-through enable released", oe_f, 0);
    idle();
    chk(oe_p == '0, "R4 pipelined enable released", oe_p, 0);
    drain(3);
  endtask

  task automatic t_fill_readback();
    for (int i = 0; i < 8; i++)
      send(1, 1, 16'h0040 + 16'(i), 36'(64'h9_0000_0000 + 64'(i * 37)));
    for (int i = 0; i < 8; i++) send(1, 0, 16'h0040 + 16'(i), '0);
    drain(6);
    chk(q_dp.size() == 0 && q_df.size() == 0, "R5 all readback responses",
        q_dp.size() + q_df.size(), 0);
  endtask

  task automatic t_interleave();
    for (int i = 0; i < 12; i++) begin
      send(1, 1, 16'h0080 + 16'(i), 36'(64'h5_5000_0000 ^ 64'(i * 911)));
      send(1, 0, 16'h0080 + 16'(i), '0);           // read right after write
      send(1, 0, 16'h0040 + 16'(i % 8), '0);       // read then write same word
      send(1, 1, 16'h0040 + 16'(i % 8), 36'(64'hC_0000_0000 + 64'(i)));
    end
    drain(6);
    chk(q_dp.size() == 0 && q_df.size() == 0, "R6 back-to-back responses",
        q_dp.size() + q_df.size(), 0);
  endtask

  task automatic t_idle_gaps();
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b1;
    req_addr  = 16'h0080;
    req_wdata = 36'hF_FFFF_FFFF;
    idle();
    chk(!mem_wr_p && !mem_wr_f, "R2 idle cycle issued as read",
        {mem_wr_p, mem_wr_f}, 0);
    for (int i = 0; i < 4; i++) begin
      idle();
      chk(oe_p == '0 && oe_f == '0, "R2 idle cycle drives bus",
          {oe_p[0], oe_f[0]}, 0);
    end
    req_write = 1'b0;
    send(1, 0, 16'h0080, '0);   // must still hold the earlier write
    idle();
    send(1, 1, 16'h0081, 36'h3_3333_3333);
    idle();
    send(1, 0, 16'h0081, '0);
    drain(6);
    chk(q_dp.size() == 0, "R2 gapped traffic responses", q_dp.size(), 0);
  endtask

  task automatic t_reset_mid();
    send(1, 0, 16'h0081, '0);
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    q_dp.delete();
    q_df.delete();
    q_cp.delete();
    q_cf.delete();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!rsp_valid_p && !rsp_valid_f, "R8 response killed by reset",
          {rsp_valid_p, rsp_valid_f}, 0);
      chk(oe_p == '0 && oe_f == '0, "R8 enables in mid-run reset",
          {oe_p[0], oe_f[0]}, 0);
    end
    rst = 1'b0;
    drain(6);
    send(1, 1, 16'h0090, 36'h7_7777_0001);
    send(1, 0, 16'h0090, '0);
    drain(6);
    chk(q_dp.size() == 0 && q_df.size() == 0, "R8 operation after reset",
        q_dp.size() + q_df.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    drain(2);
    t_issue_fields();
    t_write_timing();
    t_fill_readback();
    t_interleave();
    t_idle_gaps();
    t_reset_mid();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule